// File: doc/BRIEF.md
# Dual-Order Burst Address Generator

This block supplies the low-order word-address bits for a four-beat memory burst. A burst opens when one of two address-status strobes, one driven by a processor and one by a cache controller, is seen low at a clock edge while the device is selected. The start offset is then captured. Later cycles step through the burst while the advance input is low, and hold the current beat while it is high.

Two beat orders are supported, and either can be chosen at any cycle. The linear order counts up and wraps inside the four-slot group. The interleaved order XORs the start offset with a running beat count. A strobe seen while the device is not selected closes the burst. The processor strobe has no effect while the primary enable is inactive, so a controller can keep driving an open burst forward.

The upper address bits, write control and the storage array are handled outside this block.

Top module: `burst_addr_gen`

## Requirements
- R1: While reset is asserted, and on the first cycles after it is released, `burst_act` is 0 and `addr_lo` is 0.
- R2: If `ld_proc_n`=0, `cen_n`=0 and `cen_ok`=1 at a rising edge, `addr_lo` equals the sampled `start_addr` and `burst_act` is 1 after that edge.
- R3: If `ld_ctrl_n`=0, `cen_n`=0 and `cen_ok`=1 at a rising edge, a new burst loads in the same way even when `ld_proc_n`=1.
- R4: When `cen_n`=1, `ld_proc_n` is ignored. With `ld_ctrl_n`=1 and `adv_n`=0, an open burst moves to its next beat.
- R5: A strobe that counts, seen while the device is not selected (`cen_n`=1 or `cen_ok`=0), clears `burst_act` and leaves `addr_lo` unchanged. The processor strobe counts only when `cen_n`=0, and it takes precedence over the controller strobe.
- R6: When no strobe counts, `adv_n`=0 and `burst_act`=1, the beat count advances by one.
- R7: When no strobe counts and `adv_n`=1, `addr_lo` and `burst_act` keep their values.
- R8: When `mode_ilv`=0, beat k of a burst has offset (start + k) mod 4. For example, start 2 gives 2,3,0,1.
- R9: When `mode_ilv`=1, beat k of a burst has offset start XOR k. For example, start 1 gives 1,0,3,2.
- R10: After the fourth beat, further advances wrap within the same four-slot group.
- R11: When `burst_act`=0, `adv_n`=0 does not change `addr_lo`.
- R12: A change of `mode_ilv` during a burst changes `addr_lo` in the same cycle. The new value is derived from the start offset and the current beat count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_addr | input | 2 | Low start offset of a new burst |
| ld_proc_n | input | 1 | Processor-style address strobe, active low |
| ld_ctrl_n | input | 1 | Controller-style address strobe, active low |
| adv_n | input | 1 | Advance to the next beat, active low |
| cen_n | input | 1 | Primary chip enable, active low |
| cen_ok | input | 1 | Combined secondary enables, high when they select |
| mode_ilv | input | 1 | Beat order: 0 linear, 1 interleaved (tie high when unused) |
| addr_lo | output | 2 | Current low word-address bits |
| burst_act | output | 1 | A burst is open |

## Verification
Bursts are started from each of the four start offsets and in both orders. Matching the linear sequence against the XOR sequence distinguishes an adder from an XOR, and odd start offsets expose a swapped order. Strobes are issued under every combination of the enables, which separates a load, a close, and an ignored processor strobe that lets the controller continue. Advance runs longer than four beats check the wrap. Mid-burst order flips and advances with no open burst check that the output comes from the stored start offset and beat count rather than from the last output.

// File: rtl/bag_pkg.sv
package bag_pkg;
  // Action chosen for one clock edge
  typedef enum logic [1:0] {
    BA_HOLD = 2'd0,
    BA_STEP = 2'd1,
    BA_LOAD = 2'd2,
    BA_DROP = 2'd3
  } bag_act_e;
endpackage

// File: rtl/bag_strobe_dec.sv
module bag_strobe_dec
  import bag_pkg::*;
(
  input  logic     ld_proc_n,
  input  logic     ld_ctrl_n,
  input  logic     adv_n,
  input  logic     cen_n,
  input  logic     cen_ok,
  output bag_act_e act_o
);
  logic sel;
  logic proc_live;
  logic ctrl_live;

  always_comb begin
    sel       = !cen_n && cen_ok;
    proc_live = !ld_proc_n && !cen_n;   // processor strobe masked by primary enable
    ctrl_live = !ld_ctrl_n;
    if (proc_live || ctrl_live) begin
      act_o = sel ? BA_LOAD : BA_DROP;
    end else if (!adv_n) begin
      act_o = BA_STEP;
    end else begin
      act_o = BA_HOLD;
    end
  end
endmodule

// File: rtl/bag_beat_reg.sv
module bag_beat_reg
  import bag_pkg::*;
#(
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  bag_act_e         act_i,
  input  logic [CNT_W-1:0] start_i,
  output logic [CNT_W-1:0] base_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             busy_o
);
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] base_q, base_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             busy_q, busy_d;
  logic             base_en, cnt_en, busy_en;

  always_comb begin
    base_en = 1'b0;
    cnt_en  = 1'b0;
    busy_en = 1'b0;
    base_d  = start_i;
    cnt_d   = cnt_q + ONE;
    busy_d  = 1'b1;
    unique case (act_i)
      BA_LOAD: begin
        base_en = 1'b1;
        cnt_en  = 1'b1;
        cnt_d   = '0;
        busy_en = 1'b1;
      end
      BA_DROP: begin
        busy_en = 1'b1;
        busy_d  = 1'b0;
      end
      BA_STEP: cnt_en = busy_q;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else begin
      if (base_en) base_q <= base_d;
      if (cnt_en)  cnt_q  <= cnt_d;
      if (busy_en) busy_q <= busy_d;
    end
  end

  assign base_o = base_q;
  assign cnt_o  = cnt_q;
  assign busy_o = busy_q;

  // R6: an advance inside an open burst moves the beat count by one
  a_r6_step: assert property (@(posedge clk) disable iff (!rst_n)
    (act_i == BA_STEP && busy_q) |=> (cnt_q == $past(cnt_q) + ONE));
  // R11: an advance without an open burst changes nothing
  a_r11_idle_adv: assert property (@(posedge clk) disable iff (!rst_n)
    (act_i == BA_STEP && !busy_q) |=> ($stable(cnt_q) && $stable(base_q) && !busy_q));
  // R7: suspend keeps all state
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (act_i == BA_HOLD) |=> ($stable(cnt_q) && $stable(base_q) && $stable(busy_q)));
  // R5: a deselecting strobe closes the burst and keeps the position
  a_r5_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (act_i == BA_DROP) |=> (!busy_q && $stable(cnt_q) && $stable(base_q)));
endmodule

// File: rtl/bag_order_map.sv
module bag_order_map #(
  parameter int CNT_W = 2
) (
  input  logic             ilv_i,
  input  logic [CNT_W-1:0] base_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic [CNT_W-1:0] off_o
);
  logic [CNT_W-1:0] lin_off;
  logic [CNT_W-1:0] ilv_off;

  for (genvar b = 0; b < CNT_W; b++) begin : g_bit
    assign ilv_off[b] = base_i[b] ^ cnt_i[b];
  end

  assign lin_off = base_i + cnt_i;

  always_comb off_o = ilv_i ? ilv_off : lin_off;
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import bag_pkg::*;
#(
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] start_addr,
  input  logic             ld_proc_n,
  input  logic             ld_ctrl_n,
  input  logic             adv_n,
  input  logic             cen_n,
  input  logic             cen_ok,
  input  logic             mode_ilv,
  output logic [CNT_W-1:0] addr_lo,
  output logic             burst_act
);
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [1:0]       rst_sync_q;
  logic             rst_int_n;
  bag_act_e         act;
  logic [CNT_W-1:0] base;
  logic [CNT_W-1:0] cnt;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  bag_strobe_dec u_dec (
    .ld_proc_n (ld_proc_n),
    .ld_ctrl_n (ld_ctrl_n),
    .adv_n     (adv_n),
    .cen_n     (cen_n),
    .cen_ok    (cen_ok),
    .act_o     (act)
  );

  bag_beat_reg #(.CNT_W(CNT_W)) u_reg (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .act_i   (act),
    .start_i (start_addr),
    .base_o  (base),
    .cnt_o   (cnt),
    .busy_o  (burst_act)
  );

  bag_order_map #(.CNT_W(CNT_W)) u_map (
    .ilv_i  (mode_ilv),
    .base_i (base),
    .cnt_i  (cnt),
    .off_o  (addr_lo)
  );

  // R2: processor strobe while selected opens a burst at the start offset
  a_r2_proc_load: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!ld_proc_n && !cen_n && cen_ok) |=> (burst_act && addr_lo == $past(start_addr)));
  // R3: controller strobe while selected opens a burst
  a_r3_ctrl_load: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!ld_ctrl_n && !cen_n && cen_ok) |=> (burst_act && addr_lo == $past(start_addr)));
  // R4: processor strobe masked by the primary enable does not end the burst
  a_r4_proc_masked: assert property (@(posedge clk) disable iff (!rst_int_n)
    (cen_n && ld_ctrl_n && burst_act) |=> burst_act);
  // R8: linear order steps the offset by one, wrapping
  a_r8_linear: assert property (@(posedge clk) disable iff (!rst_int_n)
    (burst_act && ld_ctrl_n && (ld_proc_n || cen_n) && !adv_n && !mode_ilv)
      |=> (mode_ilv || addr_lo == $past(addr_lo) + ONE));
endmodule

// File: tb/sim_burst_addr_gen.sv
`timescale 1ns/1ps
module sim_burst_addr_gen;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] start_addr;
  logic       ld_proc_n, ld_ctrl_n, adv_n, cen_n, cen_ok, mode_ilv;
  logic [1:0] addr_lo;
  logic       burst_act;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  // reference state
  int m_start = 0;
  int m_cnt   = 0;
  bit m_act   = 0;

  always #2.5 clk = ~clk;

  burst_addr_gen u0 (
    .clk(clk), .rst_n(rst_n), .start_addr(start_addr),
    .ld_proc_n(ld_proc_n), .ld_ctrl_n(ld_ctrl_n), .adv_n(adv_n),
    .cen_n(cen_n), .cen_ok(cen_ok), .mode_ilv(mode_ilv),
    .addr_lo(addr_lo), .burst_act(burst_act)
  );

  function automatic int exp_addr();
    if (mode_ilv) return m_start ^ m_cnt;
    return (m_start + m_cnt) % 4;
  endfunction

  task automatic compare(input string req);
    int ea;
    ea = exp_addr();
    total++;
    if (addr_lo !== ea[1:0] || burst_act !== m_act) begin
      bad++;
      $display("FAIL %s: addr_lo=%0d burst_act=%0d expected addr_lo=%0d burst_act=%0d",
               req, addr_lo, burst_act, ea, m_act);
    end
  endtask

  // one clock: drive at negedge, update model after the edge, compare at next negedge
  task automatic cyc(input bit p_n, input bit c_n, input bit a_n, input bit ce_n,
                     input bit ok, input int st, input bit ilv, input string req);
    bit sel, pv;
    ld_proc_n = p_n; ld_ctrl_n = c_n; adv_n = a_n; cen_n = ce_n;
    cen_ok = ok; start_addr = st[1:0]; mode_ilv = ilv;
    @(posedge clk);
    sel = !ce_n && ok;
    pv  = !p_n && !ce_n;
    if (pv || !c_n) begin
      if (sel) begin m_start = st; m_cnt = 0; m_act = 1; end
      else m_act = 0;
    end else if (!a_n && m_act) begin
      m_cnt = (m_cnt + 1) % 4;
    end
    @(negedge clk);
    compare(req);
  endtask

  initial begin
    #400000;
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; ld_proc_n = 1; ld_ctrl_n = 1; adv_n = 1; cen_n = 1;
    cen_ok = 0; start_addr = 2'd3; mode_ilv = 1;
    repeat (3) @(negedge clk);
    compare("R1");                       // during reset
    rst_n = 1'b1;
    repeat (3) cyc(1,1,1,1,0,0,0,"R1");  // synchroniser release

    // R2 + R8 + R10: processor load start 2, linear, six advances
    cyc(0,1,1,0,1,2,0,"R2");
    for (int k = 0; k < 6; k++) cyc(1,1,0,0,1,0,0,"R8_R10");
    // R7: suspend
    cyc(1,1,1,0,1,1,0,"R7");
    cyc(1,1,1,0,1,3,0,"R7");

    // R3 + R9 + R10: controller load start 1, interleaved
    cyc(1,0,1,0,1,1,1,"R3");
    for (int k = 0; k < 5; k++) cyc(1,1,0,0,1,0,1,"R9_R10");

    // R4: primary enable off, processor strobe low ignored, controller high continues
    cyc(1,0,1,0,1,2,1,"R3");
    cyc(0,1,0,1,1,0,1,"R4");
    cyc(0,1,0,1,0,3,1,"R4");
    cyc(0,1,1,1,1,1,1,"R4");

    // R5: processor strobe with secondary enable failing closes the burst
    cyc(0,0,1,0,0,1,1,"R5");
    // R11: advance with no open burst
    cyc(1,1,0,0,1,0,1,"R11");
    cyc(1,1,0,0,1,0,0,"R11");

    // R5: controller strobe with primary enable off closes the burst
    cyc(0,1,1,0,1,3,0,"R2");
    cyc(1,1,0,0,1,0,0,"R6");
    cyc(1,0,1,1,1,0,0,"R5");
    cyc(1,1,0,1,1,0,0,"R11");

    // R12: mode flip mid-burst, every start offset in both orders
    for (int s = 0; s < 4; s++) begin
      cyc(0,1,1,0,1,s,s[0],"R2");
      cyc(1,1,0,0,1,0,0,"R6");
      cyc(1,1,1,0,1,0,1,"R12");
      cyc(1,1,0,0,1,0,1,"R12");
      cyc(1,1,1,0,1,0,0,"R12");
    end
    // R3: controller load while processor strobe high and selected
    cyc(1,0,1,0,1,3,1,"R3");
    cyc(1,1,0,0,1,0,1,"R9");

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule